// File: doc/BRIEF.md
# Sparse Parallel Prefix Adder

This block is a purely combinational N-bit carry-propagate adder (32 bits by default). It adds two operands and a carry-in, and returns an N-bit sum and a carry-out. Each bit first forms a generate/propagate pair, with the carry-in folded into bit 0. A sparse logarithmic prefix network then turns these pairs into the carry at every bit position, and a final XOR stage produces the sum.

The prefix network runs in two phases. The first is an up-sweep of black cells (group generate and group propagate) that merges spans at doubling distances. The second is a down-sweep of gray cells (group generate only) that fills in the carries the up-sweep left unresolved. Any column that does not combine at a level goes through an explicit buffer cell. As a result, every internal node drives at most its own column's next cell and one cross connection. The network has 2·log2 N − 1 prefix levels, and N must be a power of two, at least 2.

The block has no clock, no state and no handshake. Its outputs follow its inputs within the same evaluation, and it is meant to sit inside a pipeline stage of a larger datapath.

Top module: `spa_adder`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 2^N for any operand values.
- R2: `cout` equals bit N of the full-width value a + b + cin.
- R3: With a all ones, b zero and cin = 1, the carry travels through every bit: `sum` is zero and `cout` is 1.
- R4: With both operands zero, `sum` equals cin (0 or 1) and `cout` is 0.
- R5: A carry generated at bit k travels through a run of propagating bits above it and stops at the first bit where both operand bits are 0. Bits outside that run keep their plain XOR value.
- R6: When every bit propagates (b is the bitwise complement of a), `sum` is all ones with `cout` = 0 if cin = 0. If cin = 1, `sum` is zero and `cout` = 1.
- R7: The same network built with N = 8 meets R1 and R2.
- R8: The outputs depend only on the present inputs. A new input value is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N−1 |

## Verification
The bench goes after the longest carry paths: all-ones plus carry-in, complementary operands (every bit propagating), and single generate bits followed by propagate runs of each length ending at a kill bit. A network that took a wrong lower span in a gray or black cell would corrupt exactly the carries whose span crosses that cell. Those faults show up as wrong high sum bits for long chains, or as a carry leaking past the kill bit. A mistake in folding the carry-in would show only when cin = 1 together with a propagating bit 0, which is why zero operands and all-propagate operands are also run with cin set. Random vectors at both widths, including patterns biased toward long propagate runs, cover the mixed cases.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef enum logic [1:0] {
    CELL_BLACK = 2'd0,
    CELL_GRAY  = 2'd1,
    CELL_BUF   = 2'd2
  } cell_kind_e;

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/spa_preproc.sv
module spa_preproc #(
  parameter int N = 32
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] gen,
  output logic [N-1:0] prop
);

  for (genvar i = 0; i < N; i++) begin : bit_gp
    assign prop[i] = a[i] ^ b[i];
    if (i == 0) begin : with_cin
      // carry-in folded into the lowest generate
      assign gen[i] = (a[i] & b[i]) | ((a[i] ^ b[i]) & cin);
    end else begin : plain
      assign gen[i] = a[i] & b[i];
    end
  end

  always_comb begin
    if (prop[0]) begin
      AST_CIN_FOLD: assert (gen[0] == cin) else $error("cin fold wrong"); // R4
    end
  end

endmodule

// File: rtl/spa_prefix_cell.sv
module spa_prefix_cell
  import spa_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_BUF
) (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);

  if (KIND == CELL_BLACK) begin : black
    assign g_out = g_hi | (p_hi & g_lo);
    assign p_out = p_hi & p_lo;
  end else if (KIND == CELL_GRAY) begin : gray
    logic unused_plo;
    assign unused_plo = p_lo;
    assign g_out = g_hi | (p_hi & g_lo);
    assign p_out = 1'b0;
  end else begin : buffer
    logic unused_lo;
    assign unused_lo = g_lo | p_lo;
    assign g_out = g_hi;
    assign p_out = p_hi;
  end

endmodule

// File: rtl/spa_prefix_net.sv
module spa_prefix_net
  import spa_pkg::*;
#(
  parameter int N = 32,
  localparam int LVL = $clog2(N)
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  output logic [N-1:0] grp_g
);

  // Up-sweep: black cells where column i closes a span of 2^k bits.
  for (genvar k = 1; k <= LVL; k++) begin : up
    localparam int SPAN = 1 << (k - 1);
    logic [N-1:0] g_in, p_in, g_out, p_out;

    if (k == 1) begin : src
      assign g_in = gen;
      assign p_in = prop;
    end else begin : src
      assign g_in = up[k-1].g_out;
      assign p_in = up[k-1].p_out;
    end

    for (genvar i = 0; i < N; i++) begin : col
      if (((i + 1) % (2 * SPAN)) == 0) begin : merge
        spa_prefix_cell #(.KIND(CELL_BLACK)) u_cell (
          .g_hi(g_in[i]), .p_hi(p_in[i]),
          .g_lo(g_in[i-SPAN]), .p_lo(p_in[i-SPAN]),
          .g_out(g_out[i]), .p_out(p_out[i])
        );
      end else begin : pass
        spa_prefix_cell #(.KIND(CELL_BUF)) u_cell (
          .g_hi(g_in[i]), .p_hi(p_in[i]),
          .g_lo(1'b0), .p_lo(1'b0),
          .g_out(g_out[i]), .p_out(p_out[i])
        );
      end
    end
  end

  logic [N-1:0] top_p;
  assign top_p = up[LVL].p_out;

  // Down-sweep: gray cells fill the columns left partial by the up-sweep.
  for (genvar d = 1; d < LVL; d++) begin : dn
    localparam int K    = LVL - d;
    localparam int SPAN = 1 << (K - 1);
    logic [N-1:0] g_in, g_out;
    logic [N-1:0] unused_p;

    if (d == 1) begin : src
      assign g_in = up[LVL].g_out;
    end else begin : src
      assign g_in = dn[d-1].g_out;
    end

    for (genvar i = 0; i < N; i++) begin : col
      if ((i >= (1 << K)) && (((i + 1) % (1 << K)) == SPAN)) begin : fill
        spa_prefix_cell #(.KIND(CELL_GRAY)) u_cell (
          .g_hi(g_in[i]), .p_hi(top_p[i]),
          .g_lo(g_in[i-SPAN]), .p_lo(1'b0),
          .g_out(g_out[i]), .p_out(unused_p[i])
        );
      end else begin : pass
        spa_prefix_cell #(.KIND(CELL_BUF)) u_cell (
          .g_hi(g_in[i]), .p_hi(1'b0),
          .g_lo(1'b0), .p_lo(1'b0),
          .g_out(g_out[i]), .p_out(unused_p[i])
        );
      end
    end
  end

  if (LVL == 1) begin : fin
    logic unused_tp;
    assign unused_tp = ^top_p;
    assign grp_g = up[LVL].g_out;
  end else begin : fin
    assign grp_g = dn[LVL-1].g_out;
  end

  // Each group generate must obey the ripple recurrence on the bit pairs.
  always_comb begin
    for (int i = 1; i < N; i++) begin
      if (gen[i]) begin
        AST_CARRY_MADE: assert (grp_g[i]) else $error("generate lost at %0d", i); // R5
      end
      if (prop[i]) begin
        AST_CARRY_PASSED: assert (grp_g[i] == grp_g[i-1]) else $error("propagate broken at %0d", i); // R5
      end
      if (!gen[i] && !prop[i]) begin
        AST_CARRY_KILLED: assert (!grp_g[i]) else $error("kill ignored at %0d", i); // R5
      end
    end
  end

endmodule

// File: rtl/spa_sum_stage.sv
module spa_sum_stage #(
  parameter int N = 32
) (
  input  logic [N-1:0] prop,
  input  logic [N-1:0] grp_g,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);

  logic [N-1:0] carry_in;

  for (genvar i = 0; i < N; i++) begin : bit_sum
    if (i == 0) begin : low
      assign carry_in[i] = cin;
    end else begin : upper
      assign carry_in[i] = grp_g[i-1];
    end
    assign sum[i] = prop[i] ^ carry_in[i];
  end

  assign cout = grp_g[N-1];

endmodule

// File: rtl/spa_adder.sv
module spa_adder
  import spa_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);

  if (!is_pow2(N)) begin : bad_width
    $error("spa_adder: N must be a power of two, at least 2");
  end

  logic [N-1:0] gen, prop, grp_g;

  spa_preproc #(.N(N)) u_pre (
    .a(a), .b(b), .cin(cin), .gen(gen), .prop(prop)
  );

  spa_prefix_net #(.N(N)) u_net (
    .gen(gen), .prop(prop), .grp_g(grp_g)
  );

  spa_sum_stage #(.N(N)) u_sum (
    .prop(prop), .grp_g(grp_g), .cin(cin), .sum(sum), .cout(cout)
  );

  logic [N:0] arith;
  always_comb begin
    arith = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
    AST_SUM_LOW: assert (sum == arith[N-1:0]) else $error("sum mismatch"); // R1
    AST_CARRY_OUT: assert (cout == arith[N]) else $error("carry-out mismatch"); // R2
  end

endmodule

// File: tb/spa_adder_test.sv
`timescale 1ns/1ps
module spa_adder_test;

  localparam int W  = 32;
  localparam int W8 = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W-1:0]  a, b, sum;
  logic          cin, cout;
  logic [W8-1:0] a8, b8, sum8;
  logic          cin8, cout8;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  spa_adder #(.N(W)) uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));
  spa_adder #(.N(W8)) uut8 (.a(a8), .b(b8), .cin(cin8), .sum(sum8), .cout(cout8));

  function automatic logic [W:0] ref32(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W8:0] ref8(input logic [W8-1:0] x, input logic [W8-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W8{1'b0}}, c};
  endfunction

  // Drive away from the edge; sample mid-cycle.
  task automatic run32(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string req);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cin = c;
    #5;
    exp = ref32(x, y, c);
    checks++;
    if (sum !== exp[W-1:0]) begin
      errors++;
      $display("FAIL %s sum a=%h b=%h cin=%0b: got %h expected %h", req, x, y, c, sum, exp[W-1:0]);
    end
    checks++;
    if (cout !== exp[W]) begin
      errors++;
      $display("FAIL %s cout a=%h b=%h cin=%0b: got %0b expected %0b", req, x, y, c, cout, exp[W]);
    end
  endtask

  task automatic run8(input logic [W8-1:0] x, input logic [W8-1:0] y, input logic c);
    logic [W8:0] exp;
    @(negedge clk);
    a8 = x; b8 = y; cin8 = c;
    #5;
    exp = ref8(x, y, c);
    checks++;
    if ({cout8, sum8} !== exp) begin
      errors++;
      $display("FAIL R7 a=%h b=%h cin=%0b: got %h expected %h", x, y, c, {cout8, sum8}, exp);
    end
  endtask

  initial begin
    logic [W-1:0] ra, rb;
    a = '0; b = '0; cin = 1'b0;
    a8 = '0; b8 = '0; cin8 = 1'b0;
    void'($urandom(32'd20240601));

    // Idle state with zero inputs (R4)
    run32('0, '0, 1'b0, "R4");
    run32('0, '0, 1'b1, "R4");

    // Full-length carry (R3)
    run32('1, '0, 1'b1, "R3");
    run32('0, '1, 1'b1, "R3");
    run32('1, 32'h1, 1'b0, "R3");
    run32('1, '1, 1'b1, "R2");

    // All bits propagating (R6)
    run32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R6");
    run32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R6");
    run32(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1, "R6");
    run32(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R1");

    // Single generate bit k, propagate run of length r, kill above (R5)
    for (int k = 0; k < W; k++) begin
      for (int r = 0; r < W - k; r += 5) begin
        logic [W-1:0] run_mask;
        run_mask = '0;
        for (int j = k + 1; j <= k + r && j < W; j++) run_mask[j] = 1'b1;
        run32(32'h1 << k, (32'h1 << k) | run_mask, 1'b0, "R5");
      end
    end

    // Inputs changed without any clock edge in between (R8)
    @(negedge clk);
    a = 32'h0000_00FF; b = 32'h0000_0001; cin = 1'b0;
    #2;
    checks++;
    if (sum !== 32'h0000_0100) begin
      errors++;
      $display("FAIL R8 first value: got %h expected %h", sum, 32'h0000_0100);
    end
    a = 32'h7FFF_FFFF;
    #2;
    checks++;
    if ({cout, sum} !== 33'h0_8000_0000) begin
      errors++;
      $display("FAIL R8 second value: got %h expected %h", {cout, sum}, 33'h0_8000_0000);
    end

    // Constrained random, biased toward long propagate runs (R1, R2)
    for (int n = 0; n < 3000; n++) begin
      ra = $urandom();
      case ($urandom_range(3))
        0: rb = ~ra;
        1: rb = ~ra ^ (32'h1 << $urandom_range(W - 1));
        2: rb = $urandom() & 32'hFFFF_0000;
        default: rb = $urandom();
      endcase
      run32(ra, rb, 1'($urandom_range(1)), "R1/R2");
    end

    // Narrow build (R7)
    run8(8'hFF, 8'h00, 1'b1);
    run8(8'h00, 8'h00, 1'b0);
    run8(8'h55, 8'hAA, 1'b1);
    for (int n = 0; n < 3000; n++) begin
      run8(8'($urandom()), 8'($urandom()), 1'($urandom_range(1)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule